// File: doc/BRIEF.md
# Floating-Point Operand Screening and Trap Unit

This block sits in front of a 64-bit double-precision arithmetic datapath. It does no arithmetic. For each operand presented to it, it sorts the value into one of five classes: zero, denormal, normal, infinity or NaN. It then applies one of three screening policies and decides whether an arithmetic trap must be raised. Separately, it takes the exception flags that the arithmetic unit reports for a finished operation. It folds them into a sticky summary register and decides whether those flags raise a trap. That decision depends on an ignore mask and, in software-completion mode, an enable mask.

A trap is reported one clock after the request as a single-cycle strobe. The strobe comes with a seven-bit cause code and a one-hot register-mask word. The mask word names the destination register of the operation that faulted. Software can overwrite the sticky summary at any time. Otherwise it only collects bits, and only reset or a write clears them.

Top module: `fp_trap_screen`

## Requirements
- R1: After a synchronous active-low reset, trap_o is 0, trap_code_o is 0, trap_regmask_o is 0 and sticky_o is 0.
- R2: Bits 62:52 of the operand are the exponent and bits 51:0 the fraction. In plain mode (mode=0, also mode=3), a denormal (exponent 0, fraction nonzero) traps with code 7'h01 and leaves sticky unchanged. An infinity or NaN (exponent all ones) traps with code 7'h01 and sets sticky bit 0 (invalid). A normal value does not trap.
- R3: In compare mode (mode=1), infinities of either sign do not trap and leave sticky unchanged. A NaN (exponent all ones, fraction nonzero) traps with code 7'h01 and sets sticky bit 0. A denormal traps with code 7'h01.
- R4: In software-completion mode (mode=2), an operand traps only when it is denormal and flush_zero_i is 0. The code is then 7'h41: invalid bit 0 plus the software-completion bit 6. Sticky is unchanged, and infinities and NaNs do not trap.
- R5: An operand of zero of either sign never traps in any mode.
- R6: Flag and code bit order is 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact, 5 integer overflow. In modes 0, 1 and 3, all reported flags are ORed into sticky. The trap code is flags AND NOT ignore, and the block traps when that value is nonzero. The enable mask has no effect.
- R7: In mode 2, the filtered flags f = flags AND NOT ignore are ORed into sticky. The block traps when f is nonzero, with code (f AND enable) OR bit 6. The trap is raised even when f AND enable is zero.
- R8: For a flag-caused trap, trap_regmask_o has exactly bit dest_i set. For an operand-caused trap, and whenever no trap is raised, it is zero.
- R9: trap_o is high for exactly one cycle per cycle of request that traps. It is low, with code 0, in any cycle that follows a cycle with no request.
- R10: A cycle with sticky_we_i high loads sticky_wdata_i into sticky_o and overrides any update made in the same cycle. Otherwise sticky bits never clear.
- R11: Operand and flag requests may arrive in the same cycle. If the operand traps, its trap is reported. If it does not, the flag trap is reported. Sticky collects both contributions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid_i | input | 1 | Operand screening request |
| operand_i | input | 64 | Double-precision operand |
| mode_i | input | 2 | 0 plain, 1 compare, 2 software completion, 3 as plain |
| flush_zero_i | input | 1 | Inputs are flushed to zero (denormals tolerated in mode 2) |
| exc_valid_i | input | 1 | Exception-flag merge request |
| exc_flags_i | input | 6 | Flags reported by the arithmetic unit |
| ignore_i | input | 6 | Flags that must not trap |
| enable_i | input | 6 | Trap enable mask (mode 2 only) |
| dest_i | input | 5 | Destination register number |
| sticky_we_i | input | 1 | Overwrite sticky summary |
| sticky_wdata_i | input | 6 | Value written to sticky summary |
| trap_o | output | 1 | Trap strobe, one cycle |
| trap_code_o | output | 7 | Cause bits 5:0, software-completion bit 6 |
| trap_regmask_o | output | 32 | One-hot destination register mask |
| sticky_o | output | 6 | Sticky exception summary |

## Verification
The assertions check several properties on every cycle. Sticky bits never clear without a write. A trap has a request behind it. The register mask is never more than one-hot and appears only with a trap. A trap without the completion marker names a cause, the completion marker appears only in mode 2, and a zero operand never requests a trap. Only the bench's scenarios can show the exact codes, which depend on mode, mask and operand class, for the three screening policies. The same holds for the two flag-merge policies, including a trap with an empty cause under a zero enable mask, write priority over same-cycle updates, and arbitration between simultaneous operand and flag requests.

// File: rtl/fpts_pkg.sv
// Shared types and bit positions for the operand screening and trap unit.
package fpts_pkg;
    localparam int NFLAG    = 6;
    localparam int CODE_W   = NFLAG + 1;
    localparam int FL_INV   = 0;
    localparam int CODE_SWC = NFLAG;

    typedef enum logic [1:0] {
        MODE_PLAIN = 2'd0,
        MODE_CMP   = 2'd1,
        MODE_SWC   = 2'd2,
        MODE_ALT   = 2'd3
    } scr_mode_e;

    typedef enum logic [2:0] {
        CL_ZERO, CL_DENORM, CL_NORMAL, CL_INF, CL_NAN
    } op_class_e;
endpackage

// File: rtl/fpts_classify.sv
// Operand classifier: sorts a double-precision value into zero, denormal,
// normal, infinity or NaN. Assumes the sign bit is the MSB, which is not used.
module fpts_classify
    import fpts_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] operand,
    output op_class_e             cls
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign exp_f  = operand[FRAC_W +: EXP_W];
    assign frac_f = operand[FRAC_W-1:0];

    // Decide the class from exponent extremes and fraction occupancy.
    always_comb begin
        if (exp_f == '0)
            cls = (frac_f == '0) ? CL_ZERO : CL_DENORM;
        else if (exp_f == '1)
            cls = (frac_f == '0) ? CL_INF : CL_NAN;
        else
            cls = CL_NORMAL;
    end
endmodule

// File: rtl/fpts_screen.sv
// Operand screening policy: maps class, mode and flush setting to a trap
// request, its cause code and the sticky bits it sets. Purely combinational.
module fpts_screen
    import fpts_pkg::*;
(
    input  op_class_e         cls,
    input  scr_mode_e         mode,
    input  logic              flush_zero,
    output logic              trap_req,
    output logic [CODE_W-1:0] code,
    output logic [NFLAG-1:0]  sticky_set
);
    // Apply the policy of the selected screening mode.
    always_comb begin
        trap_req   = 1'b0;
        code       = '0;
        sticky_set = '0;
        unique case (mode)
            MODE_CMP: begin
                if (cls == CL_DENORM || cls == CL_NAN) begin
                    trap_req     = 1'b1;
                    code[FL_INV] = 1'b1;
                end
                if (cls == CL_NAN) sticky_set[FL_INV] = 1'b1;
            end
            MODE_SWC: begin
                if (cls == CL_DENORM && !flush_zero) begin
                    trap_req       = 1'b1;
                    code[FL_INV]   = 1'b1;
                    code[CODE_SWC] = 1'b1;
                end
            end
            default: begin
                if (cls == CL_DENORM || cls == CL_INF || cls == CL_NAN) begin
                    trap_req     = 1'b1;
                    code[FL_INV] = 1'b1;
                end
                if (cls == CL_INF || cls == CL_NAN) sticky_set[FL_INV] = 1'b1;
            end
        endcase
    end

    // R5: a zero operand must never request a trap.
    always_comb begin
        if (cls == CL_ZERO)
            a_r5_zero_pass: assert (!trap_req);
    end
endmodule

// File: rtl/fpts_flag_merge.sv
// Exception-flag merge policy: filters reported flags by the ignore mask
// and, with software completion, by the enable mask. Purely combinational.
module fpts_flag_merge
    import fpts_pkg::*;
(
    input  logic [NFLAG-1:0]  flags,
    input  logic [NFLAG-1:0]  ignore,
    input  logic [NFLAG-1:0]  enable,
    input  logic              swc,
    output logic              trap_req,
    output logic [CODE_W-1:0] code,
    output logic [NFLAG-1:0]  sticky_set
);
    logic [NFLAG-1:0] kept;

    assign kept = flags & ~ignore;

    // Choose sticky contribution and trap code per completion mode.
    always_comb begin
        trap_req = (kept != '0);
        if (swc) begin
            sticky_set = kept;
            code       = {1'b1, kept & enable};
        end else begin
            sticky_set = flags;
            code       = {1'b0, kept};
        end
    end
endmodule

// File: rtl/fp_trap_screen.sv
// Operand screening and trap unit top. Registers trap strobe, cause code,
// one-hot register mask and sticky summary. Assumes requests are valid for
// the cycle they are asserted; results appear one clock later.
module fp_trap_screen
    import fpts_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int NREG   = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          op_valid_i,
    input  logic [EXP_W+FRAC_W:0]         operand_i,
    input  logic [1:0]                    mode_i,
    input  logic                          flush_zero_i,
    input  logic                          exc_valid_i,
    input  logic [fpts_pkg::NFLAG-1:0]    exc_flags_i,
    input  logic [fpts_pkg::NFLAG-1:0]    ignore_i,
    input  logic [fpts_pkg::NFLAG-1:0]    enable_i,
    input  logic [$clog2(NREG)-1:0]       dest_i,
    input  logic                          sticky_we_i,
    input  logic [fpts_pkg::NFLAG-1:0]    sticky_wdata_i,
    output logic                          trap_o,
    output logic [fpts_pkg::CODE_W-1:0]   trap_code_o,
    output logic [NREG-1:0]               trap_regmask_o,
    output logic [fpts_pkg::NFLAG-1:0]    sticky_o
);
    localparam int REG_W = $clog2(NREG);

    scr_mode_e         mode_e;
    op_class_e         cls;
    logic              scr_trap, mrg_trap, sel_op, sel_flag;
    logic [CODE_W-1:0] scr_code, mrg_code;
    logic [NFLAG-1:0]  scr_set, mrg_set;
    logic [NREG-1:0]   dest_onehot;

    assign mode_e = scr_mode_e'(mode_i);

    fpts_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
        .operand (operand_i),
        .cls     (cls)
    );

    fpts_screen u_scr (
        .cls        (cls),
        .mode       (mode_e),
        .flush_zero (flush_zero_i),
        .trap_req   (scr_trap),
        .code       (scr_code),
        .sticky_set (scr_set)
    );

    fpts_flag_merge u_mrg (
        .flags      (exc_flags_i),
        .ignore     (ignore_i),
        .enable     (enable_i),
        .swc        (mode_e == MODE_SWC),
        .trap_req   (mrg_trap),
        .code       (mrg_code),
        .sticky_set (mrg_set)
    );

    // Decode the destination register number into a one-hot word.
    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign dest_onehot[g] = (dest_i == REG_W'(g));
    end

    assign sel_op   = op_valid_i && scr_trap;
    assign sel_flag = !sel_op && exc_valid_i && mrg_trap;

    // Register the trap report and update the sticky summary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_o         <= 1'b0;
            trap_code_o    <= '0;
            trap_regmask_o <= '0;
            sticky_o       <= '0;
        end else begin
            trap_o         <= sel_op || sel_flag;
            trap_code_o    <= sel_op ? scr_code : (sel_flag ? mrg_code : '0);
            trap_regmask_o <= sel_flag ? dest_onehot : '0;
            if (sticky_we_i)
                sticky_o <= sticky_wdata_i;
            else
                sticky_o <= sticky_o | (op_valid_i ? scr_set : '0)
                                     | (exc_valid_i ? mrg_set : '0);
        end
    end

    // R10: without a write, sticky bits never clear.
    a_r10_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sticky_we_i |=> ((sticky_o & $past(sticky_o)) == $past(sticky_o)));

    // R9: a trap is always caused by a request in the previous cycle.
    a_r9_trap_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> $past(op_valid_i || exc_valid_i));

    // R8: the register mask is at most one-hot and only comes with a trap.
    a_r8_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(trap_regmask_o) && ((trap_regmask_o == '0) || trap_o));

    // R7: the completion marker only appears for mode 2 requests.
    a_r7_swc_marker: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && trap_code_o[CODE_SWC]) |-> ($past(mode_i) == 2'd2));

    // R6: a trap without the completion marker names at least one cause.
    a_r6_cause_present: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && !trap_code_o[CODE_SWC]) |-> (trap_code_o[NFLAG-1:0] != '0));
endmodule

// File: tb/sim_fp_trap_screen.sv
// Directed bench for fp_trap_screen: one task per scenario.
module sim_fp_trap_screen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [63:0] operand = '0;
    logic [1:0]  mode = '0;
    logic        flush = 1'b0;
    logic        exc_valid = 1'b0;
    logic [5:0]  flags = '0, ign = '0, en = '0, wdata = '0;
    logic [4:0]  dest = '0;
    logic        we = 1'b0;
    logic        trap;
    logic [6:0]  code;
    logic [31:0] rmask;
    logic [5:0]  sticky;

    int total = 0;
    int bad = 0;

    localparam logic [63:0] V_ZERO = 64'h0000_0000_0000_0000;
    localparam logic [63:0] V_NZER = 64'h8000_0000_0000_0000;
    localparam logic [63:0] V_DEN  = 64'h0000_0000_0000_0001;
    localparam logic [63:0] V_NORM = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] V_INF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] V_NINF = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] V_NAN  = 64'h7FF8_0000_0000_0000;

    always #10 clk = ~clk;

    fp_trap_screen u0 (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .operand_i(operand),
        .mode_i(mode), .flush_zero_i(flush), .exc_valid_i(exc_valid),
        .exc_flags_i(flags), .ignore_i(ign), .enable_i(en), .dest_i(dest),
        .sticky_we_i(we), .sticky_wdata_i(wdata), .trap_o(trap),
        .trap_code_o(code), .trap_regmask_o(rmask), .sticky_o(sticky)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_out(input string tag, input logic et, input logic [6:0] ec,
                              input logic [31:0] em, input logic [5:0] es);
        chk({tag, " trap"}, {31'd0, trap}, {31'd0, et});
        chk({tag, " code"}, {25'd0, code}, {25'd0, ec});
        chk({tag, " mask"}, rmask, em);
        chk({tag, " sticky"}, {26'd0, sticky}, {26'd0, es});
    endtask

    // Drive one request at the negedge, let one posedge capture it, sample at the next negedge.
    task automatic step(input logic ov, input logic [63:0] op, input logic [1:0] md,
                        input logic fl, input logic ev, input logic [5:0] f,
                        input logic [5:0] ig, input logic [5:0] e, input logic [4:0] d,
                        input logic w, input logic [5:0] wd);
        op_valid = ov; operand = op; mode = md; flush = fl;
        exc_valid = ev; flags = f; ign = ig; en = e; dest = d; we = w; wdata = wd;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0; exc_valid = 1'b0; we = 1'b0;
    endtask

    task automatic screen(input logic [63:0] op, input logic [1:0] md, input logic fl);
        step(1'b1, op, md, fl, 1'b0, '0, '0, '0, '0, 1'b0, '0);
    endtask

    task automatic merge(input logic [1:0] md, input logic [5:0] f, input logic [5:0] ig,
                         input logic [5:0] e, input logic [4:0] d);
        step(1'b0, '0, md, 1'b0, 1'b1, f, ig, e, d, 1'b0, '0);
    endtask

    task automatic clear_sticky();
        step(1'b0, '0, 2'd0, 1'b0, 1'b0, '0, '0, '0, '0, 1'b1, '0);
    endtask

    task automatic t_reset();
        expect_out("R1 reset", 1'b0, 7'h00, 32'h0, 6'h00);
    endtask

    task automatic t_plain();
        screen(V_NORM, 2'd0, 1'b0); expect_out("R2 plain normal", 0, 7'h00, 0, 6'h00);
        screen(V_DEN, 2'd0, 1'b0);  expect_out("R2 plain denorm", 1, 7'h01, 0, 6'h00);
        screen(V_INF, 2'd0, 1'b0);  expect_out("R2 plain inf", 1, 7'h01, 0, 6'h01);
        clear_sticky();             expect_out("R10 write clears", 0, 7'h00, 0, 6'h00);
        screen(V_NAN, 2'd3, 1'b0);  expect_out("R2 mode3 nan", 1, 7'h01, 0, 6'h01);
        clear_sticky();
    endtask

    task automatic t_compare();
        screen(V_INF, 2'd1, 1'b0);  expect_out("R3 cmp inf", 0, 7'h00, 0, 6'h00);
        screen(V_NINF, 2'd1, 1'b0); expect_out("R3 cmp neg inf", 0, 7'h00, 0, 6'h00);
        screen(V_NAN, 2'd1, 1'b0);  expect_out("R3 cmp nan", 1, 7'h01, 0, 6'h01);
        screen(V_DEN, 2'd1, 1'b0);  expect_out("R3 cmp denorm", 1, 7'h01, 0, 6'h01);
        clear_sticky();
    endtask

    task automatic t_swc_screen();
        screen(V_DEN, 2'd2, 1'b0);  expect_out("R4 swc denorm", 1, 7'h41, 0, 6'h00);
        screen(V_DEN, 2'd2, 1'b1);  expect_out("R4 swc denorm flushed", 0, 7'h00, 0, 6'h00);
        screen(V_NAN, 2'd2, 1'b0);  expect_out("R4 swc nan", 0, 7'h00, 0, 6'h00);
        screen(V_INF, 2'd2, 1'b0);  expect_out("R4 swc inf", 0, 7'h00, 0, 6'h00);
    endtask

    task automatic t_zero();
        for (int m = 0; m < 4; m++) begin
            screen(V_ZERO, 2'(m), 1'b0); expect_out("R5 zero", 0, 7'h00, 0, 6'h00);
            screen(V_NZER, 2'(m), 1'b0); expect_out("R5 neg zero", 0, 7'h00, 0, 6'h00);
        end
    endtask

    task automatic t_flags_plain();
        merge(2'd0, 6'h14, 6'h10, 6'h00, 5'd5);
        expect_out("R6 plain flags", 1, 7'h04, 32'h0000_0020, 6'h14);
        merge(2'd0, 6'h10, 6'h10, 6'h3F, 5'd9);
        expect_out("R6 all ignored", 0, 7'h00, 0, 6'h14);
        merge(2'd1, 6'h02, 6'h00, 6'h00, 5'd31);
        expect_out("R8 cmp flags reg31", 1, 7'h02, 32'h8000_0000, 6'h16);
        step(1'b0, '0, 2'd0, 1'b0, 1'b0, '0, '0, '0, '0, 1'b0, '0);
        expect_out("R9 idle after trap", 0, 7'h00, 0, 6'h16);
        clear_sticky();
    endtask

    task automatic t_flags_swc();
        merge(2'd2, 6'h18, 6'h10, 6'h08, 5'd3);
        expect_out("R7 swc enabled", 1, 7'h48, 32'h0000_0008, 6'h08);
        merge(2'd2, 6'h04, 6'h00, 6'h00, 5'd0);
        expect_out("R7 swc not enabled", 1, 7'h40, 32'h0000_0001, 6'h0C);
        merge(2'd2, 6'h10, 6'h10, 6'h3F, 5'd2);
        expect_out("R7 swc ignored", 0, 7'h00, 0, 6'h0C);
        clear_sticky();
    endtask

    task automatic t_write_priority();
        step(1'b0, '0, 2'd0, 1'b0, 1'b1, 6'h02, 6'h00, 6'h00, 5'd1, 1'b1, 6'h21);
        expect_out("R10 write over merge", 1, 7'h02, 32'h0000_0002, 6'h21);
        clear_sticky();
    endtask

    task automatic t_both();
        step(1'b1, V_DEN, 2'd0, 1'b0, 1'b1, 6'h04, 6'h00, 6'h00, 5'd7, 1'b0, '0);
        expect_out("R11 operand wins", 1, 7'h01, 0, 6'h04);
        step(1'b1, V_NORM, 2'd0, 1'b0, 1'b1, 6'h04, 6'h00, 6'h00, 5'd7, 1'b0, '0);
        expect_out("R11 flag when operand clean", 1, 7'h04, 32'h0000_0080, 6'h04);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_compare();
        t_swc_screen();
        t_zero();
        t_flags_plain();
        t_flags_swc();
        t_write_priority();
        t_both();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule